// File: doc/BRIEF.md
# Update-Event Timer with Trigger Output

This block is an up-counting time base. A prescaler divides the input clock. The main counter then runs from zero up to a reload value, and on the next tick it wraps back to zero. That wrap is the update event. It can latch a sticky status flag, raise a one-cycle DMA request pulse and pulse a trigger output. The trigger output paces a downstream converter, for example a DAC that takes one sample per update. The prescaler and the reload value are both programmed as N-1. A divide-by-N setting is written as N-1, so 0 means divide by 1.

A small synchronous register port reaches every control. Writes take effect on the clock edge. Reads are combinational from the current address. The port sets the run state, chooses which event sources may set the flag, turns reload buffering on or off, selects the trigger mode, sets the request enables, and issues a software update. The software update restarts the count and copies the buffered settings into the active copies.

Top module: `uevt_timer`

## Requirements
- R1: After reset, every register reads 0 except the reload register, which reads all ones. Trigger, DMA request and interrupt outputs are 0. The register map, with bit positions, is:
  - address 0, control: bit0 run, bit1 overflow-only, bit2 buffered reload, bits 6:4 trigger mode.
  - address 1, enables: bit0 interrupt, bit1 DMA.
  - address 2, status: bit0 update flag.
  - address 3, event: bit0 software update. Reads as 0.
  - address 4: counter.
  - address 5: prescaler.
  - address 6: reload.
  - address 7: reads as 0.
- R2: While running, an update event occurs once every (P+1)*(A+1) clock cycles, where P is the prescaler value and A the reload value.
- R3: The counter counts up from 0 and wraps to 0 on the tick after it reaches the reload value. In trigger mode 010 the trigger output is high for one cycle per update, in the same cycle that the counter reads 0.
- R4: With buffered reload set, a reload write takes effect only from the next update event. With it clear, a reload write takes effect at once, including within the current period.
- R5: A prescaler write takes effect only from the next update event.
- R6: Writing 1 to bit0 at address 3 produces an update event, even when the timer is stopped. The counter goes to 0, and the prescaler and reload values are loaded into their active copies.
- R7: With overflow-only set, a software update sets neither the flag nor the DMA request, while a counter overflow still sets both. With overflow-only clear, both kinds of update set them.
- R8: The update flag stays set until a write to address 2 with bit0 = 0 clears it. A write with bit0 = 1 leaves it unchanged. The interrupt output is the flag ANDed with the interrupt enable.
- R9: When DMA enable is set, each flag-setting update produces a one-cycle DMA request pulse, whatever the trigger mode. When DMA enable is clear, no request is made.
- R10: Trigger mode 000 pulses the trigger on a software update only. Mode 001 drives the trigger with the run bit. Mode 010 pulses it on every update. All other modes hold it at 0.
- R11: With run at 0, the counter holds its value. Setting run again resumes counting from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for the current address |
| trig_out | output | 1 | Trigger output to a downstream converter |
| dma_req | output | 1 | One-cycle DMA request pulse |
| irq | output | 1 | Interrupt: update flag AND interrupt enable |

## Verification
A register write lands on the clock edge that follows its strobe. The trigger pulse and the DMA pulse are registered, so both appear in the first cycle after the edge that decides the update. That is the same cycle in which the counter reads 0. The flag and the counter are readable in that same cycle, and the mode 001 trigger level follows the run bit with no added delay. The bench drives on the falling edge and samples just after it. It logs the cycle number of every trigger and DMA pulse, and checks periods as differences between logged cycles, so the start-up latency never enters the expected value. Checks that follow a write read the outputs in the first half-cycle after the landing edge. A resume check expects exactly one count of progress.

// File: rtl/uevt_timer.sv
module uevt_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          trig_out,
  output logic          dma_req,
  output logic          irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STAT = 3'd2, A_EVT = 3'd3,
                         A_CNT = 3'd4, A_PSC = 3'd5, A_ARR = 3'd6;
  localparam logic [2:0] M_SWU = 3'b000, M_RUN = 3'b001, M_UPD = 3'b010;

  logic          run, urs, arpe, ie, de, flag, trig_q, dma_q;
  logic [2:0]    mode;
  logic [CW-1:0] cnt, pcnt, psc_buf, psc_act, arr_buf, arr_act;

  wire ug      = we && addr == A_EVT && wdata[0];
  wire tick    = run && pcnt >= psc_act;
  wire [CW-1:0] arr_eff = arpe ? arr_act : arr_buf;
  wire ovf     = tick && cnt >= arr_eff;
  wire uev     = ovf || ug;
  wire flag_ev = ovf || (ug && !urs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; urs <= 1'b0; arpe <= 1'b0; mode <= 3'd0;
      ie <= 1'b0; de <= 1'b0; flag <= 1'b0;
    end else begin
      if (we && addr == A_CTRL) begin
        run  <= wdata[0];
        urs  <= wdata[1];
        arpe <= wdata[2];
        mode <= wdata[6:4];
      end
      if (we && addr == A_IEN) begin
        ie <= wdata[0];
        de <= wdata[1];
      end
      if (flag_ev) flag <= 1'b1;
      else if (we && addr == A_STAT && !wdata[0]) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_buf <= '0;
      arr_buf <= '1;
    end else begin
      if (we && addr == A_PSC) psc_buf <= wdata;
      if (we && addr == A_ARR) arr_buf <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pcnt <= '0; psc_act <= '0; arr_act <= '1;
    end else if (uev) begin
      cnt     <= '0;
      pcnt    <= '0;
      psc_act <= psc_buf;
      arr_act <= arr_buf;
    end else begin
      if (we && addr == A_CNT) cnt <= wdata;
      else if (tick)           cnt <= cnt + 1'b1;
      if (tick)     pcnt <= '0;
      else if (run) pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      trig_q <= (mode == M_UPD && uev) || (mode == M_SWU && ug);
      dma_q  <= flag_ev && de;
    end
  end

  assign trig_out = trig_q || (mode == M_RUN && run);
  assign dma_req  = dma_q;
  assign irq      = flag && ie;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(CW-7){1'b0}}, mode, 1'b0, arpe, urs, run};
      A_IEN:   rdata = {{(CW-2){1'b0}}, de, ie};
      A_STAT:  rdata = {{(CW-1){1'b0}}, flag};
      A_CNT:   rdata = cnt;
      A_PSC:   rdata = psc_buf;
      A_ARR:   rdata = arr_buf;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/uevt_timer_chk.sv
module uevt_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [2:0]    addr,
  input logic          wd0,
  input logic          run,
  input logic          urs,
  input logic          de,
  input logic          flag,
  input logic [2:0]    mode,
  input logic [CW-1:0] cnt,
  input logic          trig_out,
  input logic          dma_req
);
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(we && addr == 3'd2 && !wd0)) |=> flag); // R8
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(we && (addr == 3'd4 || (addr == 3'd3 && wd0)))) |=> $stable(cnt)); // R11
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> !dma_req); // R9
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && mode == 3'b010 && $past(mode) == 3'b010) |-> cnt == '0); // R3
  AST_SWU_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (urs && !run && we && addr == 3'd3 && wd0) |=> !dma_req); // R7
endmodule

bind uevt_timer uevt_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wd0(wdata[0]),
  .run(run), .urs(urs), .de(de), .flag(flag), .mode(mode), .cnt(cnt),
  .trig_out(trig_out), .dma_req(dma_req)
);

// File: tb/sim_uevt_timer.sv
module sim_uevt_timer;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = '0, rdata;
  logic trig_out, dma_req, irq;
  int checks = 0, errors = 0, cyc = 0, tn = 0, dn = 0;
  int tlog[512];
  bit done = 1'b0;

  uevt_timer #(.CW(16)) u0 (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig_out(trig_out), .dma_req(dma_req), .irq(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (trig_out) begin
      if (tn < 512) tlog[tn] = cyc;
      tn++;
    end
    if (dma_req) dn++;
  end

  function automatic int exp_period(int p, int a);
    return (p + 1) * (a + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    #2;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk); addr = a; #1; v = int'(rdata);
  endtask

  task automatic wait_trig(int target);
    for (int i = 0; i < 4000; i++) begin
      if (tn >= target) return;
      @(negedge clk); #2;
    end
    chk(1'b0, "trigger wait timeout", tn, target);
  endtask

  task automatic setup(int p, int a, logic [15:0] ctrl, output int s);
    wr(3'd0, 16'h0); wr(3'd5, 16'(p)); wr(3'd6, 16'(a)); wr(3'd3, 16'h1); wr(3'd2, 16'h0);
    s = tn;
    wr(3'd0, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, s, p, a, c1, c2, d0, t0;
    v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd1, v); chk(v == 0, "R1 enables", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 counter", v, 0);
    rd(3'd5, v); chk(v == 0, "R1 prescaler", v, 0);
    rd(3'd6, v); chk(v == 16'hFFFF, "R1 reload", v, 16'hFFFF);
    chk({trig_out, dma_req, irq} == 3'b000, "R1 outputs", {trig_out, dma_req, irq}, 0);

    // R2 R3 R9: random prescaler/reload, period and DMA alignment
    wr(3'd1, 16'h2);
    for (int t = 0; t < 10; t++) begin
      p = $urandom % 4; a = $urandom % 10;
      if (t == 0) begin p = 0; a = 0; end
      setup(p, a, 16'h21, s);
      d0 = dn;
      wait_trig(s + 3);
      wr(3'd0, 16'h20);
      chk(tlog[s+2] - tlog[s+1] == exp_period(p, a), "R2 period", tlog[s+2] - tlog[s+1], exp_period(p, a));
      chk(dn - d0 == tn - s, "R9 dma with trigger", dn - d0, tn - s);
    end

    // R3: counter reads 0 while trigger pulses
    setup(1, 5, 16'h21, s);
    wait_trig(s + 1);
    rd(3'd4, v);
    chk(v == 0 || v == 1, "R3 counter near wrap", v, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); addr = 3'd4; #1;
      if (trig_out) chk(rdata == 0, "R3 zero at trigger", int'(rdata), 0);
    end

    // R4 unbuffered reload
    setup(0, 9, 16'h21, s);
    wait_trig(s + 1);
    wr(3'd6, 16'd4);
    wait_trig(s + 3);
    chk(tlog[s+1] - tlog[s] == 5, "R4 immediate reload", tlog[s+1] - tlog[s], 5);
    chk(tlog[s+2] - tlog[s+1] == 5, "R4 immediate reload next", tlog[s+2] - tlog[s+1], 5);
    // R4 buffered reload
    setup(0, 9, 16'h25, s);
    wait_trig(s + 1);
    wr(3'd6, 16'd4);
    wait_trig(s + 3);
    chk(tlog[s+1] - tlog[s] == 10, "R4 buffered current", tlog[s+1] - tlog[s], 10);
    chk(tlog[s+2] - tlog[s+1] == 5, "R4 buffered next", tlog[s+2] - tlog[s+1], 5);

    // R5 prescaler takes effect at next update
    setup(0, 3, 16'h21, s);
    wait_trig(s + 1);
    wr(3'd5, 16'd1);
    wait_trig(s + 3);
    chk(tlog[s+1] - tlog[s] == 4, "R5 old prescaler", tlog[s+1] - tlog[s], 4);
    chk(tlog[s+2] - tlog[s+1] == 8, "R5 new prescaler", tlog[s+2] - tlog[s+1], 8);

    // R11 freeze and resume
    setup(0, 200, 16'h21, s);
    repeat (20) @(negedge clk);
    wr(3'd0, 16'h20);
    rd(3'd4, c1);
    repeat (5) @(negedge clk);
    rd(3'd4, c2);
    chk(c1 == c2 && c1 != 0, "R11 frozen", c2, c1);
    wr(3'd0, 16'h21);
    rd(3'd4, v);
    chk(v == c2 + 1, "R11 resume", v, c2 + 1);
    wr(3'd0, 16'h20);

    // R6 software update while stopped
    wr(3'd3, 16'h1);
    chk(trig_out == 1'b1, "R6 update trigger", trig_out, 1);
    rd(3'd4, v); chk(v == 0, "R6 counter cleared", v, 0);

    // R7 overflow-only
    wr(3'd2, 16'h0);
    wr(3'd0, 16'h22);
    wr(3'd3, 16'h1);
    chk(dma_req == 1'b0, "R7 no dma on sw update", dma_req, 0);
    chk(trig_out == 1'b1, "R7 trigger still on sw update", trig_out, 1);
    rd(3'd2, v); chk(v == 0, "R7 no flag on sw update", v, 0);
    wr(3'd0, 16'h20);
    wr(3'd3, 16'h1);
    chk(dma_req == 1'b1, "R7 dma on sw update", dma_req, 1);
    rd(3'd2, v); chk(v == 1, "R7 flag on sw update", v, 1);
    setup(0, 3, 16'h23, s);
    wait_trig(s + 1);
    wr(3'd0, 16'h22);
    rd(3'd2, v); chk(v == 1, "R7 flag on overflow", v, 1);

    // R8 sticky flag and interrupt
    wr(3'd2, 16'h1);
    rd(3'd2, v); chk(v == 1, "R8 write one keeps flag", v, 1);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(3'd1, 16'h3);
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk(v == 1, "R8 flag held", v, 1);
    wr(3'd2, 16'h0);
    rd(3'd2, v); chk(v == 0, "R8 flag cleared", v, 0);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);

    // R9 R10 mode 000: DMA on overflow, no trigger on overflow
    setup(0, 3, 16'h01, s);
    t0 = tn; d0 = dn;
    repeat (24) @(negedge clk);
    #2;
    chk(tn == t0, "R10 mode 000 no overflow trigger", tn - t0, 0);
    chk(dn - d0 >= 5, "R9 dma independent of mode", dn - d0, 6);
    wr(3'd0, 16'h00);
    wr(3'd3, 16'h1);
    chk(trig_out == 1'b1, "R10 mode 000 sw trigger", trig_out, 1);

    // R10 mode 001 level, mode 011 silent
    wr(3'd0, 16'h10);
    chk(trig_out == 1'b0, "R10 mode 001 stopped", trig_out, 0);
    wr(3'd0, 16'h11);
    chk(trig_out == 1'b1, "R10 mode 001 running", trig_out, 1);
    wr(3'd0, 16'h30);
    wr(3'd3, 16'h1);
    t0 = tn;
    wr(3'd0, 16'h31);
    repeat (30) @(negedge clk);
    #2;
    chk(tn == t0, "R10 mode 011 silent", tn - t0, 0);
    wr(3'd0, 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule